// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the sharer record of one memory block for a coherence home node in a machine of `NODES` nodes. While few nodes share the block, the record holds exact node numbers in `NPTR` pointer slots. When one more distinct sharer arrives than the slots can hold, the record falls back to a less exact form. The `POLICY` parameter picks that form. Under the coarse policy the record becomes a group vector, with one bit for each run of `GROUP` consecutive nodes. Under the broadcast policy the record becomes a flag meaning "every node". Under the evict policy there is no fallback: the record replaces an old sharer and tells the caller to invalidate it.

The caller issues one operation per clock on `op_code`/`op_node`. An add records a new sharer. A clear empties the record. A write asks for the set of nodes to invalidate, and the requesting writer is never part of that set. `sharer_mask` shows at every moment, as a node mask, the set of nodes the record stands for. Invalidation masks appear one clock after the operation on `inval_valid`/`inval_mask`.

Top module: `lim_dir_entry`

## Requirements
- R1: While reset is asserted, and right after it, `sharer_mask` is zero and `overflow`, `inval_valid` and `inval_mask` are all zero.
- R2: In pointer mode, add (`op_code`=1) of a new node with a free slot records it, and from the next clock `sharer_mask` bit `op_node` is set. With no overflow, `sharer_mask` has at most `NPTR` bits set.
- R3: Adding a node that is already recorded leaves `sharer_mask` and `overflow` unchanged and raises no invalidation.
- R4: A write (`op_code`=3) raises `inval_valid` for exactly the next clock. `inval_mask` equals `sharer_mask` with bit `op_node` cleared. The write leaves the record unchanged. No-op (`op_code`=0) and clear raise no invalidation.
- R5: Under the coarse policy, adding a new distinct sharer while all `NPTR` slots are full sets `overflow`. In the same step, `sharer_mask` becomes the union of the groups of every recorded node and of the new node, where the group of node n covers nodes GROUP*(n/GROUP) to GROUP*(n/GROUP)+GROUP-1.
- R6: Under the coarse policy with `overflow` set, an add sets the group of `op_node`, and a write invalidates every node of every set group except the writer.
- R7: Under the broadcast policy, the add that overflows sets `overflow` and makes `sharer_mask` all ones. A later write then invalidates every node except the writer.
- R8: Under the evict policy, `overflow` never rises. An add of a new node to a full record replaces the pointer in the slot named by a round-robin index that starts at slot 0 and steps by one for each eviction. On the next clock, `inval_valid` is high and `inval_mask` holds only the evicted node.
- R9: Clear (`op_code`=2) empties the record, drops `overflow` and moves the eviction index back to slot 0, all in one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 2 | 0 no-op, 1 add sharer, 2 clear, 3 write |
| op_node | input | $clog2(NODES) | Node the operation names |
| sharer_mask | output | NODES | Nodes the record currently stands for |
| overflow | output | 1 | Record has left exact pointer form |
| inval_valid | output | 1 | Invalidation mask valid this clock |
| inval_mask | output | NODES | Nodes to invalidate |

## Verification
A wrong slot count or a stale pointer shows up in `sharer_mask` on the clock after the add that caused it, and shows up again in the mask of the next write. A group vector folded wrongly at overflow appears in `sharer_mask` in the same clock as `overflow` rises. A round-robin index off by one names the wrong victim in `inval_mask` at the second eviction after a clear. An index that a clear fails to reset shows at the first eviction after that clear.

// File: rtl/lim_dir_pkg.sv
package lim_dir_pkg;

  // overflow handling choices
  localparam int POL_BCAST  = 0;
  localparam int POL_EVICT  = 1;
  localparam int POL_COARSE = 2;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ADD   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_WRITE = 2'd3
  } dir_op_e;

endpackage

// File: rtl/lim_dir_match.sv
// Compares one node number against every live pointer slot.
module lim_dir_match #(
  parameter int NPTR = 2,
  parameter int NW   = 4,
  parameter int CW   = 2
) (
  input  logic [NPTR-1:0][NW-1:0] ptr_i,
  input  logic [CW-1:0]           cnt_i,
  input  logic [NW-1:0]           node_i,
  output logic                    hit_o
);

  logic [NPTR-1:0] slot_hit;

  for (genvar i = 0; i < NPTR; i++) begin : g_slot
    assign slot_hit[i] = (CW'(i) < cnt_i) && (ptr_i[i] == node_i);
  end

  assign hit_o = |slot_hit;

endmodule

// File: rtl/lim_dir_expand.sv
// Turns the stored representation into a per-node mask.
module lim_dir_expand
  import lim_dir_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int NPTR   = 2,
  parameter int GROUP  = 2,
  parameter int POLICY = POL_COARSE,
  parameter int NW     = 4,
  parameter int CW     = 2,
  localparam int NGRP  = NODES / GROUP
) (
  input  logic [NPTR-1:0][NW-1:0] ptr_i,
  input  logic [CW-1:0]           cnt_i,
  input  logic                    ovf_i,
  input  logic [NGRP-1:0]         grp_i,
  output logic [NODES-1:0]        ptr_mask_o,
  output logic [NODES-1:0]        sharer_mask_o
);

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic hit_n;

    always_comb begin
      hit_n = 1'b0;
      for (int i = 0; i < NPTR; i++) begin
        if ((CW'(i) < cnt_i) && (ptr_i[i] == NW'(n))) hit_n = 1'b1;
      end
    end

    assign ptr_mask_o[n] = hit_n;

    if (POLICY == POL_BCAST) begin : g_bc
      // group bits stay zero under this policy
      assign sharer_mask_o[n] = ovf_i | hit_n | grp_i[n / GROUP];
    end else if (POLICY == POL_COARSE) begin : g_cv
      assign sharer_mask_o[n] = ovf_i ? grp_i[n / GROUP] : hit_n;
    end else begin : g_ev
      // overflow and group bits stay zero under this policy
      assign sharer_mask_o[n] = hit_n | (ovf_i & grp_i[n / GROUP]);
    end
  end

endmodule

// File: rtl/lim_dir_entry.sv
module lim_dir_entry
  import lim_dir_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int NPTR   = 2,
  parameter int GROUP  = 2,
  parameter int POLICY = POL_COARSE,
  localparam int NW    = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_code,
  input  logic [NW-1:0]    op_node,
  output logic [NODES-1:0] sharer_mask,
  output logic             overflow,
  output logic             inval_valid,
  output logic [NODES-1:0] inval_mask
);

  localparam int NGRP = NODES / GROUP;
  localparam int CW   = $clog2(NPTR + 1);
  localparam int VW   = (NPTR > 1) ? $clog2(NPTR) : 1;

  dir_op_e op;
  assign op = dir_op_e'(op_code);

  logic [NPTR-1:0][NW-1:0] ptr_q, ptr_d;
  logic [CW-1:0]           cnt_q, cnt_d;
  logic                    ovf_q, ovf_d;
  logic [NGRP-1:0]         grp_q, grp_d;
  logic [VW-1:0]           vic_q, vic_d;
  logic                    iv_q, iv_d;
  logic [NODES-1:0]        im_q, im_d;

  logic                    hit;
  logic                    state_en;
  logic [NODES-1:0]        ptr_mask, share_mask, node_oh, vic_oh;
  logic [NGRP-1:0]         ptr_grp, node_grp;

  assign node_oh = {{(NODES-1){1'b0}}, 1'b1} << op_node;
  assign vic_oh  = {{(NODES-1){1'b0}}, 1'b1} << ptr_q[vic_q];

  lim_dir_match #(.NPTR(NPTR), .NW(NW), .CW(CW)) u_match (
    .ptr_i  (ptr_q),
    .cnt_i  (cnt_q),
    .node_i (op_node),
    .hit_o  (hit)
  );

  lim_dir_expand #(
    .NODES(NODES), .NPTR(NPTR), .GROUP(GROUP), .POLICY(POLICY),
    .NW(NW), .CW(CW)
  ) u_expand (
    .ptr_i         (ptr_q),
    .cnt_i         (cnt_q),
    .ovf_i         (ovf_q),
    .grp_i         (grp_q),
    .ptr_mask_o    (ptr_mask),
    .sharer_mask_o (share_mask)
  );

  // fold node masks into group bits
  for (genvar g = 0; g < NGRP; g++) begin : g_fold
    assign ptr_grp[g]  = |ptr_mask[g*GROUP +: GROUP];
    assign node_grp[g] = |node_oh[g*GROUP +: GROUP];
  end

  assign state_en = (op == OP_ADD) || (op == OP_CLEAR);

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    grp_d = grp_q;
    vic_d = vic_q;
    iv_d  = 1'b0;
    im_d  = '0;
    unique case (op)
      OP_ADD: begin
        if (ovf_q) begin
          if (POLICY == POL_COARSE) grp_d = grp_q | node_grp;
        end else if (!hit) begin
          if (cnt_q < CW'(NPTR)) begin
            for (int i = 0; i < NPTR; i++) begin
              if (CW'(i) == cnt_q) ptr_d[i] = op_node;
            end
            cnt_d = cnt_q + CW'(1);
          end else if (POLICY == POL_COARSE) begin
            ovf_d = 1'b1;
            grp_d = ptr_grp | node_grp;
          end else if (POLICY == POL_BCAST) begin
            ovf_d = 1'b1;
          end else begin
            iv_d         = 1'b1;
            im_d         = vic_oh;
            ptr_d[vic_q] = op_node;
            vic_d        = (vic_q == VW'(NPTR - 1)) ? '0 : vic_q + VW'(1);
          end
        end
      end
      OP_CLEAR: begin
        ptr_d = '0;
        cnt_d = '0;
        ovf_d = 1'b0;
        grp_d = '0;
        vic_d = '0;
      end
      OP_WRITE: begin
        iv_d = 1'b1;
        im_d = share_mask & ~node_oh;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      grp_q <= '0;
      vic_q <= '0;
    end else if (state_en) begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      grp_q <= grp_d;
      vic_q <= vic_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q <= 1'b0;
      im_q <= '0;
    end else begin
      iv_q <= iv_d;
      im_q <= im_d;
    end
  end

  assign sharer_mask = share_mask;
  assign overflow    = ovf_q;
  assign inval_valid = iv_q;
  assign inval_mask  = im_q;

endmodule

// File: rtl/lim_dir_entry_chk.sv
module lim_dir_entry_chk
  import lim_dir_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int NPTR   = 2,
  parameter int GROUP  = 2,
  parameter int POLICY = POL_COARSE,
  localparam int NW    = $clog2(NODES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       op_code,
  input logic [NW-1:0]    op_node,
  input logic [NODES-1:0] sharer_mask,
  input logic             overflow,
  input logic             inval_valid,
  input logic [NODES-1:0] inval_mask
);

  p_add_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_ADD) |=> sharer_mask[$past(op_node)]);

  p_ptr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow |-> ($countones(sharer_mask) <= NPTR));

  p_write_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_WRITE) |=> (inval_valid && !inval_mask[$past(op_node)]));

  p_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_WRITE) |=> ($stable(sharer_mask) && $stable(overflow)));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_NOP || op_code == OP_CLEAR) |=> !inval_valid);

  p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CLEAR) |=> (sharer_mask == '0 && !overflow));

  if (POLICY == POL_EVICT) begin : g_ev
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !overflow);
    p_single_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inval_valid && $past(op_code == OP_ADD)) |-> ($countones(inval_mask) == 1));
  end else if (POLICY == POL_BCAST) begin : g_bc
    p_bcast_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (&sharer_mask));
  end else begin : g_cv
    p_coarse_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && op_code != OP_CLEAR) |=> overflow);
  end

endmodule

bind lim_dir_entry lim_dir_entry_chk #(
  .NODES(NODES), .NPTR(NPTR), .GROUP(GROUP), .POLICY(POLICY)
) u_chk (.*);

// File: tb/lim_dir_entry_test.sv
module lim_dir_entry_test;
  import lim_dir_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op = 2'd0;
  logic [3:0] node = 4'd0;

  // index 0 broadcast, 1 evict, 2 coarse
  logic [15:0] sh [3];
  logic [15:0] im [3];
  logic        ov [3];
  logic        iv [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  lim_dir_entry #(.POLICY(POL_BCAST)) uut_bc (
    .clk(clk), .rst_n(rst_n), .op_code(op), .op_node(node),
    .sharer_mask(sh[0]), .overflow(ov[0]), .inval_valid(iv[0]), .inval_mask(im[0]));
  lim_dir_entry #(.POLICY(POL_EVICT)) uut_ev (
    .clk(clk), .rst_n(rst_n), .op_code(op), .op_node(node),
    .sharer_mask(sh[1]), .overflow(ov[1]), .inval_valid(iv[1]), .inval_mask(im[1]));
  lim_dir_entry #(.POLICY(POL_COARSE)) uut (
    .clk(clk), .rst_n(rst_n), .op_code(op), .op_node(node),
    .sharer_mask(sh[2]), .overflow(ov[2]), .inval_valid(iv[2]), .inval_mask(im[2]));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model
  bit [15:0] m_set [3];
  bit        m_ovf [3];
  int        m_ptr [3][$];
  int        m_vic [3];
  bit        e_iv  [3];
  bit [15:0] e_im  [3];

  function automatic bit [15:0] oh(int n);
    return 16'h1 << n;
  endfunction

  function automatic bit [15:0] gm(int n);
    return 16'h3 << (n & 14);
  endfunction

  function automatic bit [15:0] cur_set(int p);
    bit [15:0] s = '0;
    if (m_ovf[p]) return (p == 0) ? 16'hFFFF : m_set[p];
    foreach (m_ptr[p][i]) s |= oh(m_ptr[p][i]);
    return s;
  endfunction

  task automatic model_op(int p, int o, int n);
    bit present = 1'b0;
    e_iv[p] = 1'b0;
    e_im[p] = '0;
    foreach (m_ptr[p][i]) if (m_ptr[p][i] == n) present = 1'b1;
    case (o)
      1: begin
        if (m_ovf[p]) begin
          if (p == 2) m_set[p] |= gm(n);
        end else if (!present) begin
          if (m_ptr[p].size() < 2) m_ptr[p].push_back(n);
          else if (p == 2) begin
            m_set[p] = gm(m_ptr[p][0]) | gm(m_ptr[p][1]) | gm(n);
            m_ovf[p] = 1'b1;
          end else if (p == 0) m_ovf[p] = 1'b1;
          else begin
            e_iv[p] = 1'b1;
            e_im[p] = oh(m_ptr[p][m_vic[p]]);
            m_ptr[p][m_vic[p]] = n;
            m_vic[p] = (m_vic[p] + 1) % 2;
          end
        end
      end
      2: begin
        m_ptr[p].delete();
        m_ovf[p] = 1'b0;
        m_set[p] = '0;
        m_vic[p] = 0;
      end
      3: begin
        e_iv[p] = 1'b1;
        e_im[p] = cur_set(p) & ~oh(n);
      end
      default: ;
    endcase
  endtask

  task automatic cmp(string tag, string what, int p, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s policy%0d actual=%h expected=%h", tag, what, p, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int p = 0; p < 3; p++) begin
      cmp(tag, "sharer_mask", p, sh[p], cur_set(p));
      cmp(tag, "overflow", p, {15'd0, ov[p]}, {15'd0, m_ovf[p]});
      cmp(tag, "inval_valid", p, {15'd0, iv[p]}, {15'd0, e_iv[p]});
      cmp(tag, "inval_mask", p, im[p], e_im[p]);
    end
  endtask

  task automatic step(int o, int n, string tag);
    @(negedge clk);
    op = o[1:0];
    node = n[3:0];
    for (int p = 0; p < 3; p++) model_op(p, o, n);
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  initial begin
    for (int p = 0; p < 3; p++) begin
      m_set[p] = '0; m_ovf[p] = 1'b0; m_vic[p] = 0; e_iv[p] = 1'b0; e_im[p] = '0;
    end
    #(CLK_PERIOD*2 + 1);
    compare_all("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    compare_all("R1 after reset");

    step(1, 3, "R2 add first");
    step(1, 3, "R3 duplicate add");
    step(3, 5, "R4 write other");
    step(3, 3, "R4 writer excluded");
    step(1, 9, "R2 add second");
    step(0, 0, "R4 nop quiet");
    step(3, 0, "R4 write two ptrs");
    step(1, 9, "R3 duplicate full");
    step(1, 12, "R5 R7 R8 overflow add");
    step(3, 13, "R6 R7 write after overflow");
    step(1, 4, "R6 R8 second overflow add");
    step(3, 12, "R6 R7 write excl");
    step(1, 0, "R8 wrap eviction");
    step(2, 0, "R9 clear");
    step(3, 1, "R9 write after clear");
    step(1, 1, "R2 add after clear");
    step(1, 2, "R2 add");
    step(1, 3, "R5 R8 evict from slot0 after clear");
    step(3, 2, "R6 R7 R4 write");
    step(1, 15, "R6 add in coarse");
    step(3, 15, "R6 write");
    step(2, 0, "R9 clear again");
    step(1, 7, "R2 single");
    step(3, 7, "R4 only sharer is writer");

    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
        int r;
        int o;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r = int'(lfsr);
        case (r % 10)
          0, 1, 2, 3, 4: o = 1;
          5, 6, 7: o = 3;
          8: o = 0;
          default: o = 2;
        endcase
        step(o, (r >> 4) & 15, "R2 R5 R6 R7 R8 mixed");
      end
    end

    @(negedge clk);
    op = 2'd0;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule